// File: doc/BRIEF.md
# Scan Cycle Down-Counter

This block decides how many test clock cycles a scan operation receives. A host loads a 32-bit start value through an 8-bit byte port, one byte per write strobe, least significant byte first; the fourth byte commits the whole value. While counting is enabled, the block counts down by one on every cycle in which the gated test clock pulses. It holds that clock off whenever no usable count is present, which means none was loaded or the count has run down to zero.

Three mode bits are written through a separate mode strobe. They enable counting, enable forcing of the test mode select line on the final counted cycle, and enable an interrupt request. Counting is enabled after reset. The shifter datapath that surrounds the block is represented by a clock request input (`tck_req`) and a serial TMS input (`tms_in`). The block returns the gated clock pulse and the possibly forced TMS value.

Top module: `scan_cycle_counter`

## Requirements
- R1: Four writes on `wr_en` assemble the count. The first byte of a sequence fills bits 7:0, then 15:8, then 23:16, then 31:24. The full value appears on `count_value` after the fourth write, and the next write starts again at bits 7:0.
- R2: The first three writes of a load sequence leave `count_value` and `cnt_active` unchanged.
- R3: With counting enabled and `cnt_active` low, `count_blocked` is 1 and `tck_pulse` is 0 whatever `tck_req` is. With counting enabled and `cnt_active` high, `tck_pulse` equals `tck_req`.
- R4: With counting enabled, `count_value` falls by exactly one after each cycle in which `tck_pulse` is 1. It does not change in a cycle with no pulse and no completed load.
- R5: `cnt_active` is 1 exactly when a count has been loaded and has not reached zero. Loading zero leaves it 0, and counting down to zero clears it.
- R6: When the auto-TMS mode bit is set, counting is enabled and the active count equals 1, `tms_out` is 1. Otherwise `tms_out` equals `tms_in`.
- R7: When the interrupt-enable mode bit is set, `irq` equals the inverse of `cnt_active`. When the bit is clear, `irq` is 0.
- R8: `mode_data` bit 0 enables counting, bit 1 enables auto-TMS and bit 2 enables the interrupt. Reset sets the mode to 3'b001.
- R9: With counting disabled, `tck_pulse` equals `tck_req`, `count_blocked` is 0 and the count holds.
- R10: A load completed in the same cycle as a clock pulse takes the written value, and that pulse does not decrement it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe for the count |
| wr_data | input | 8 | Byte written into the count |
| mode_wr | input | 1 | Mode register write strobe |
| mode_data | input | 3 | Mode value: bit 0 count enable, bit 1 auto-TMS, bit 2 interrupt enable |
| tck_req | input | 1 | Test clock request from the shifters |
| tms_in | input | 1 | Serial TMS bit from the TMS shifter |
| tck_pulse | output | 1 | Gated test clock enable |
| count_blocked | output | 1 | Counter is holding the test clock off |
| tms_out | output | 1 | TMS after auto-high forcing |
| irq | output | 1 | Interrupt request |
| cnt_active | output | 1 | Count loaded and not yet at zero |
| count_value | output | 32 | Current count |

## Verification
The assertions check on every cycle that an active count is never zero and that a blocked clock never pulses. They also check that each enabled pulse lowers the count by one, that the count holds otherwise, that TMS forcing happens only at a count of one, and that the interrupt stays low while an enabled count is active. The bench scenarios cover the properties that no single cycle shows. These are the byte order and pointer wrap of a load, a partial load leaving the old count in place, a zero load, running down to the terminal count, disabled counting, and a load colliding with a clock pulse.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int CNT_W  = 32;
  localparam int BYTE_W = 8;
  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int PTR_W  = $clog2(NBYTES);
  localparam int MODE_W = 3;

  typedef struct packed {
    logic irq_en;
    logic auto_tms;
    logic cnt_en;
  } mode_t;

  localparam mode_t MODE_RESET = '{irq_en: 1'b0, auto_tms: 1'b0, cnt_en: 1'b1};

  function automatic logic [CNT_W-1:0] assemble(input logic [BYTE_W-1:0] top,
                                                input logic [CNT_W-BYTE_W-1:0] low);
    return {top, low};
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return c - 1'b1;
  endfunction

  function automatic logic is_last(input logic [CNT_W-1:0] c);
    return c == {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/scc_byte_loader.sv
module scc_byte_loader
  import scc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              commit,
  output logic [CNT_W-1:0]  load_val
);
  localparam int STAGE_W = CNT_W - BYTE_W;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

  logic [PTR_W-1:0]   ptr;
  logic [STAGE_W-1:0] stage;

  assign commit   = wr_en && (ptr == LAST);
  assign load_val = assemble(wr_data, stage);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_en) begin
      ptr <= commit ? '0 : ptr + 1'b1;
    end
  end

  for (genvar b = 0; b < NBYTES - 1; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[b*BYTE_W +: BYTE_W] <= '0;
      end else if (wr_en && ptr == PTR_W'(b)) begin
        stage[b*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/scc_down_counter.sv
module scc_down_counter
  import scc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [CNT_W-1:0] load_val,
  input  logic             decr,
  output logic [CNT_W-1:0] count,
  output logic             loaded
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      loaded <= 1'b0;
    end else if (commit) begin
      count  <= load_val;
      loaded <= (load_val != '0);
    end else if (decr && loaded) begin
      count  <= next_count(count);
      loaded <= !is_last(count);
    end
  end
endmodule

// File: rtl/scc_gate.sv
module scc_gate
  import scc_pkg::*;
(
  input  mode_t            mode,
  input  logic             loaded,
  input  logic [CNT_W-1:0] count,
  input  logic             tck_req,
  input  logic             tms_in,
  output logic             blocked,
  output logic             pulse,
  output logic             decr,
  output logic             tms_force,
  output logic             tms_out,
  output logic             irq
);
  always_comb begin
    blocked   = mode.cnt_en && !loaded;
    pulse     = tck_req && !blocked;
    decr      = pulse && mode.cnt_en;
    tms_force = mode.auto_tms && mode.cnt_en && loaded && is_last(count);
    tms_out   = tms_in || tms_force;
    irq       = mode.irq_en && !loaded;
  end
endmodule

// File: rtl/scan_cycle_counter.sv
module scan_cycle_counter
  import scc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_data,
  input  logic              tck_req,
  input  logic              tms_in,
  output logic              tck_pulse,
  output logic              count_blocked,
  output logic              tms_out,
  output logic              irq,
  output logic              cnt_active,
  output logic [CNT_W-1:0]  count_value
);
  mode_t            mode;
  logic             commit_w;
  logic [CNT_W-1:0] load_val_w;
  logic             decr_w;
  logic             loaded_w;
  logic             tms_force_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_RESET;
    else if (mode_wr) mode <= mode_t'(mode_data);
  end

  scc_byte_loader u_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .commit(commit_w), .load_val(load_val_w)
  );

  scc_down_counter u_counter (
    .clk(clk), .rst_n(rst_n), .commit(commit_w), .load_val(load_val_w),
    .decr(decr_w), .count(count_value), .loaded(loaded_w)
  );

  scc_gate u_gate (
    .mode(mode), .loaded(loaded_w), .count(count_value), .tck_req(tck_req),
    .tms_in(tms_in), .blocked(count_blocked), .pulse(tck_pulse), .decr(decr_w),
    .tms_force(tms_force_w), .tms_out(tms_out), .irq(irq)
  );

  assign cnt_active = loaded_w;
endmodule

// File: rtl/scan_cycle_counter_checker.sv
module scan_cycle_counter_checker
  import scc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tck_pulse,
  input logic             count_blocked,
  input logic             cnt_active,
  input logic [CNT_W-1:0] count_value,
  input logic             irq,
  input logic             commit_w,
  input logic             tms_force_w,
  input mode_t            mode
);
  assert_active_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_active |-> count_value != '0);

  assert_blocked_no_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_blocked |-> !tck_pulse);

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_pulse && mode.cnt_en && !commit_w) |=> count_value == $past(count_value) - 1'b1);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tck_pulse && !commit_w) |=> $stable(count_value));

  assert_force_at_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tms_force_w |-> (count_value == 32'd1 && cnt_active));

  assert_quiet_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_active |-> !irq);
endmodule

bind scan_cycle_counter scan_cycle_counter_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tck_pulse(tck_pulse), .count_blocked(count_blocked),
  .cnt_active(cnt_active), .count_value(count_value), .irq(irq),
  .commit_w(commit_w), .tms_force_w(tms_force_w), .mode(mode)
);

// File: tb/scan_cycle_counter_test.sv
module scan_cycle_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_data = '0;
  logic        tck_req = 1'b0;
  logic        tms_in = 1'b0;
  logic        tck_pulse, count_blocked, tms_out, irq, cnt_active;
  logic [31:0] count_value;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  logic [31:0] m_cnt = '0;
  logic        m_en = 1'b1;
  logic        pulse_seen = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  scan_cycle_counter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mode_wr(mode_wr), .mode_data(mode_data), .tck_req(tck_req), .tms_in(tms_in),
    .tck_pulse(tck_pulse), .count_blocked(count_blocked), .tms_out(tms_out),
    .irq(irq), .cnt_active(cnt_active), .count_value(count_value)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: one expected count per enabled, non-loading clock pulse
  always @(posedge clk) pulse_seen <= tck_pulse && m_en && !wr_en;

  always @(negedge clk) begin
    if (pulse_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 actual unexpected decrement %0h expected none", count_value);
      end else begin
        check("R4 scoreboard count", count_value, exp_q.pop_front());
      end
    end
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load(input logic [31:0] v);
    for (int i = 0; i < 4; i++) write_byte(v[i*8 +: 8]);
    m_cnt = v;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_data = m;
    @(negedge clk); mode_wr = 1'b0;
    m_en = m[0];
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tck_req = 1'b1;
      if (m_en && m_cnt != 0) begin
        m_cnt = m_cnt - 1;
        exp_q.push_back(m_cnt);
      end
    end
    @(negedge clk); tck_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset mode: counting enabled, so unloaded counter blocks; irq off
    tck_req = 1'b1; #1;
    check("R8/R3 reset blocked", count_blocked, 1);
    check("R3 reset no pulse", tck_pulse, 0);
    check("R7 reset irq disabled", irq, 0);
    check("R5 reset inactive", cnt_active, 0);
    tms_in = 1'b1; #1;
    check("R6 tms passthrough", tms_out, 1);
    tms_in = 1'b0; tck_req = 1'b0;

    // R1 byte order
    load(32'h1234_5678);
    check("R1 assembled value", count_value, 32'h1234_5678);
    check("R5 active after load", cnt_active, 1);
    tck_req = 1'b1; #1;
    check("R3 pulse follows request", tck_pulse, 1);
    tck_req = 1'b0; #1;
    check("R3 no request no pulse", tck_pulse, 0);

    // R1 pointer wrap: second load starts at byte 0
    load(32'h0000_0005);
    check("R1 wrap reload", count_value, 5);

    // R2 partial load keeps old count
    write_byte(8'hAA); write_byte(8'hBB); write_byte(8'hCC);
    check("R2 partial count", count_value, 5);
    check("R2 partial active", cnt_active, 1);
    write_byte(8'h00);
    m_cnt = 32'h00CC_BBAA;
    check("R1 completed load", count_value, 32'h00CC_BBAA);

    // R4 holds without request
    repeat (3) @(negedge clk);
    check("R4 hold without pulse", count_value, 32'h00CC_BBAA);

    // R4/R5/R6/R3 run down to terminal count
    load(32'd4);
    set_mode(3'b011);
    run(2);
    check("R4 after two pulses", count_value, 2);
    #1;
    check("R6 no force at two", tms_out, 0);
    run(1);
    check("R4 count one", count_value, 1);
    #1;
    check("R6 forced at one", tms_out, 1);
    run(3);
    check("R5 expired inactive", cnt_active, 0);
    check("R4 stops at zero", count_value, 0);
    tck_req = 1'b1; #1;
    check("R3 expired no pulse", tck_pulse, 0);
    check("R6 no force at zero", tms_out, 0);
    tck_req = 1'b0;

    // R7 interrupt
    set_mode(3'b101);
    #1;
    check("R7 irq when expired", irq, 1);
    load(32'd2);
    check("R7 irq low when active", irq, 0);
    set_mode(3'b001);
    check("R7 irq disabled", irq, 0);

    // R5 zero load
    load(32'd0);
    check("R5 zero load inactive", cnt_active, 0);
    check("R3 zero load blocked", count_blocked, 1);

    // R9 disabled
    set_mode(3'b000);
    load(32'd9);
    tck_req = 1'b1; #1;
    check("R9 pulse follows request", tck_pulse, 1);
    check("R9 not blocked", count_blocked, 0);
    run(3);
    check("R9 count holds", count_value, 9);
    set_mode(3'b001);

    // R10 load collides with pulse
    load(32'd7);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h20;
    @(negedge clk); wr_data = 8'h00;
    @(negedge clk);
    @(negedge clk); tck_req = 1'b1;
    @(negedge clk); wr_en = 1'b0; tck_req = 1'b0;
    m_cnt = 32'h20;
    @(negedge clk);
    check("R10 load wins over pulse", count_value, 32'h20);
    run(1);
    check("R4 after collision", count_value, 32'h1F);

    @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule